// File: doc/BRIEF.md
# Paged Address Mapper

This block sits between a 16-bit processor and an 18-bit physical memory. The address space seen by the processor is split into eight pages of 8 KB. Each page is relocated through a base register that counts in 64-byte blocks. The result is an 18-bit physical address. The page registers used for a translation depend on the current processor mode, which is taken from the top two bits of the processor status word. Three modes are supported, and each has its own bank of registers. Translation is purely combinational. Software reaches the page registers and one control register through a single-cycle register port that decodes addresses in the I/O page.

Each bank holds sixteen base/descriptor pairs: eight for instruction space and eight for data space. Translation always uses the instruction-space base registers of the selected bank. Two addresses bypass the normal path:
- The lowest 512 bytes of the virtual space always go through the kernel bank.
- The top 8 KB is the I/O page. It is flagged and passed through without relocation.

Every write access through a mapped page records itself by setting a written flag in that page's descriptor.

Top module: `page_mapper`

## Requirements
- R1: For a mapped access, physAddr = (base register of the selected bank's instruction-space page vAddr[15:13]) × 64 + vAddr[12:0], truncated to 18 bits.
- R2: modeBits selects the bank: 2'b00 kernel, 2'b01 supervisor, 2'b11 user; the reserved value 2'b10 uses the user bank.
- R3: Any vAddr below octal 01000 is translated with the kernel bank whatever modeBits holds.
- R4: A vAddr at or above octal 0160000 sets ioHit to 1. In that case physAddr = octal 0760000 + vAddr[12:0], and no descriptor is marked. Below that address ioHit is 0.
- R5: When accValid and accWrite are both high on a clock edge for a mapped address, bit 6 of the instruction-space descriptor for that page, in the bank used for translation, becomes 1. A read access marks nothing.
- R6: After reset, every base register of page index p (0..7, in both spaces and all banks) reads p × 128. Every descriptor reads 16'h7F06, which is access field bits 3:1 = 3 and length field bits 14:8 = 127. The control register reads 0.
- R7: Register windows start at octal 0172300 (kernel), 0172200 (supervisor) and 0177600 (user), and each is 64 bytes long. The offset within a window is kind×32 + space×16 + page×2, where kind is 0 for descriptor and 1 for base, and space is 0 for instruction and 1 for data. Address bit 0 is ignored. Reads of any other address return 0, and writes to any other address change nothing.
- R8: The control register at octal 0177572 stores written data with bits 11 and 10 cleared. It always reads those two bits as 0.
- R9: For a byte access, byteEn is 2'b10 when physAddr[0] is 1 and 2'b01 otherwise. For a word access, byteEn is 2'b11.
- R10: If a register write and a marking write access hit the same descriptor in one cycle, the descriptor takes regWdata with bit 6 set.
- R11: regRdata follows regAddr combinationally. A register write is visible from the next cycle, and it changes the translation from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vAddr | input | 16 | Virtual address from the processor |
| modeBits | input | 2 | Status word bits 15:14, the current mode |
| accValid | input | 1 | A memory access is taking place this cycle |
| accWrite | input | 1 | The access is a write |
| accByte | input | 1 | The access is a byte access |
| physAddr | output | 18 | Translated physical address |
| ioHit | output | 1 | The address falls in the I/O page |
| byteEn | output | 2 | Byte lane enables |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 16 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data |

## Verification
A software update to a descriptor can land in the same clock as a write access that marks that same descriptor. The bench provokes this directly: it drives a register write to a user instruction-space descriptor while a user-mode write targets the same page, then reads the descriptor back and expects the written data with bit 6 set. It also provokes the mixed case, where the two actions hit different pages in the same cycle, and both effects must survive. In addition, random phases interleave register writes with marking accesses.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;

  localparam int VA_W        = 16;
  localparam int PA_W        = 18;
  localparam int OFF_W       = 13;
  localparam int PAGES       = 8;
  localparam int PAGE_W      = $clog2(PAGES);
  localparam int NUM_SETS    = 3;
  localparam int SET_W       = $clog2(NUM_SETS);
  localparam int BLOCK_SHIFT = 6;
  localparam int REG_W       = 16;
  localparam int HI_W        = VA_W - 9;
  localparam int WRITTEN_BIT = 6;

  localparam logic [REG_W-1:0] PAR_STEP    = REG_W'((1 << OFF_W) >> BLOCK_SHIFT);
  localparam logic [REG_W-1:0] PDR_RESET   = 16'h7F06;
  localparam logic [REG_W-1:0] MMR0_ADDR   = 16'o177572;
  localparam logic [REG_W-1:0] MMR0_CLR    = 16'h0C00;
  localparam logic [REG_W-1:0] WIN_KERNEL  = 16'o172300;
  localparam logic [REG_W-1:0] WIN_SUPER   = 16'o172200;
  localparam logic [REG_W-1:0] WIN_USER    = 16'o177600;
  localparam logic [REG_W-1:0] WIN_MASK    = 16'h003F;

  localparam logic [SET_W-1:0] SET_KERNEL = 0;
  localparam logic [SET_W-1:0] SET_SUPER  = 1;
  localparam logic [SET_W-1:0] SET_USER   = 2;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_PDR  = 2'd1,
    REG_PAR  = 2'd2,
    REG_CTRL = 2'd3
  } regKind_e;

  typedef struct packed {
    regKind_e          regKind;
    logic [SET_W-1:0]  regSet;
    logic              regD;
    logic [PAGE_W-1:0] regPage;
    logic              regWrEn;
    logic              markEn;
    logic [SET_W-1:0]  xlatSet;
    logic [PAGE_W-1:0] xlatPage;
    logic              ioHit;
  } mapStrobe_t;

endpackage

// File: rtl/page_mapper_ctrl.sv
module page_mapper_ctrl
  import page_mapper_pkg::*;
(
  input  logic [HI_W-1:0]  vHigh,
  input  logic [1:0]       modeBits,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             regWr,
  input  logic [REG_W-1:0] regAddr,
  output mapStrobe_t       strobe
);

  logic             winHit;
  logic [SET_W-1:0] winSet;
  logic             ctrlHit;
  logic             lowZone;
  logic             ioZone;
  logic [SET_W-1:0] modeSet;

  // register window decode; address bit 0 is folded away by the masks
  always_comb begin
    winHit = 1'b1;
    winSet = SET_KERNEL;
    if ((regAddr | WIN_MASK) == (WIN_KERNEL | WIN_MASK)) begin
      winSet = SET_KERNEL;
    end else if ((regAddr | WIN_MASK) == (WIN_SUPER | WIN_MASK)) begin
      winSet = SET_SUPER;
    end else if ((regAddr | WIN_MASK) == (WIN_USER | WIN_MASK)) begin
      winSet = SET_USER;
    end else begin
      winHit = 1'b0;
    end
    ctrlHit = (regAddr | 16'h0001) == (MMR0_ADDR | 16'h0001);
  end

  // bank selection for translation
  always_comb begin
    unique case (modeBits)
      2'b00:   modeSet = SET_KERNEL;
      2'b01:   modeSet = SET_SUPER;
      default: modeSet = SET_USER;
    endcase
    ioZone  = &vHigh[HI_W-1:HI_W-3];
    lowZone = vHigh == '0;
  end

  always_comb begin
    strobe = '0;
    if (winHit) begin
      strobe.regKind = regAddr[5] ? REG_PAR : REG_PDR;
    end else if (ctrlHit) begin
      strobe.regKind = REG_CTRL;
    end else begin
      strobe.regKind = REG_NONE;
    end
    strobe.regSet   = winSet;
    strobe.regD     = regAddr[4];
    strobe.regPage  = regAddr[3:1];
    strobe.regWrEn  = regWr;
    strobe.ioHit    = ioZone;
    strobe.xlatSet  = lowZone ? SET_KERNEL : modeSet;
    strobe.xlatPage = vHigh[HI_W-1:HI_W-PAGE_W];
    strobe.markEn   = accValid && accWrite && !ioZone;
  end

endmodule

// File: rtl/page_mapper_dp.sv
module page_mapper_dp
  import page_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mapStrobe_t       strobe,
  input  logic [OFF_W-1:0] vOffset,
  input  logic             accByte,
  input  logic [REG_W-1:0] regWdata,
  output logic [PA_W-1:0]  physAddr,
  output logic [1:0]       byteEn,
  output logic [REG_W-1:0] regRdata
);

  logic [REG_W-1:0] parQ [NUM_SETS][2][PAGES];
  logic [REG_W-1:0] pdrQ [NUM_SETS][2][PAGES];
  logic [REG_W-1:0] parD [NUM_SETS][2][PAGES];
  logic [REG_W-1:0] pdrD [NUM_SETS][2][PAGES];
  logic [REG_W-1:0] ctrlQ;

  // next-state: software write first, the written mark is OR-ed on top
  always_comb begin
    parD = parQ;
    pdrD = pdrQ;
    if (strobe.regWrEn && strobe.regKind == REG_PAR) begin
      parD[strobe.regSet][strobe.regD][strobe.regPage] = regWdata;
    end
    if (strobe.regWrEn && strobe.regKind == REG_PDR) begin
      pdrD[strobe.regSet][strobe.regD][strobe.regPage] = regWdata;
    end
    if (strobe.markEn) begin
      pdrD[strobe.xlatSet][0][strobe.xlatPage][WRITTEN_BIT] = 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar d = 0; d < 2; d++) begin : g_space
      for (genvar p = 0; p < PAGES; p++) begin : g_page
        always_ff @(posedge clk) begin
          if (!rstN) begin
            parQ[s][d][p] <= REG_W'(p) * PAR_STEP;
            pdrQ[s][d][p] <= PDR_RESET;
          end else begin
            parQ[s][d][p] <= parD[s][d][p];
            pdrQ[s][d][p] <= pdrD[s][d][p];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (strobe.regWrEn && strobe.regKind == REG_CTRL) begin
      ctrlQ <= regWdata & ~MMR0_CLR;
    end
  end

  // translation
  logic [REG_W-1:0]             base;
  logic [REG_W+BLOCK_SHIFT-1:0] scaled;
  logic [PA_W-1:0]              physMapped;

  always_comb begin
    base       = parQ[strobe.xlatSet][0][strobe.xlatPage];
    scaled     = {base, {BLOCK_SHIFT{1'b0}}};
    physMapped = scaled[PA_W-1:0] + {{(PA_W-OFF_W){1'b0}}, vOffset};
    physAddr   = strobe.ioHit ? {{(PA_W-OFF_W){1'b1}}, vOffset} : physMapped;
    if (accByte) begin
      byteEn = physAddr[0] ? 2'b10 : 2'b01;
    end else begin
      byteEn = 2'b11;
    end
  end

  // register read mux
  always_comb begin
    unique case (strobe.regKind)
      REG_PAR:  regRdata = parQ[strobe.regSet][strobe.regD][strobe.regPage];
      REG_PDR:  regRdata = pdrQ[strobe.regSet][strobe.regD][strobe.regPage];
      REG_CTRL: regRdata = ctrlQ;
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import page_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  vAddr,
  input  logic [1:0]       modeBits,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             accByte,
  output logic [PA_W-1:0]  physAddr,
  output logic             ioHit,
  output logic [1:0]       byteEn,
  input  logic             regWr,
  input  logic [REG_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata
);

  mapStrobe_t strobe;

  page_mapper_ctrl u_ctrl (
    .vHigh    (vAddr[VA_W-1:9]),
    .modeBits (modeBits),
    .accValid (accValid),
    .accWrite (accWrite),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .strobe   (strobe)
  );

  page_mapper_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .vOffset  (vAddr[OFF_W-1:0]),
    .accByte  (accByte),
    .regWdata (regWdata),
    .physAddr (physAddr),
    .byteEn   (byteEn),
    .regRdata (regRdata)
  );

  assign ioHit = strobe.ioHit;

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk
  import page_mapper_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [VA_W-1:0]  vAddr,
  input logic             accByte,
  input logic [PA_W-1:0]  physAddr,
  input logic             ioHit,
  input logic [1:0]       byteEn,
  input logic [REG_W-1:0] regAddr,
  input logic [REG_W-1:0] regRdata
);

  AST_IO_TOP_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    ioHit |-> (&physAddr[PA_W-1:OFF_W]) && physAddr[OFF_W-1:0] == vAddr[OFF_W-1:0]); // R4

  AST_BLOCK_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    !ioHit |-> physAddr[BLOCK_SHIFT-1:0] == vAddr[BLOCK_SHIFT-1:0]); // R1

  AST_CTRL_ZERO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr | 16'h0001) == (MMR0_ADDR | 16'h0001)) |-> regRdata[11:10] == 2'b00); // R8

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    accByte |-> $countones(byteEn) == 1 && byteEn[1] == physAddr[0]); // R9

  AST_WORD_BOTH_LANES: assert property (@(posedge clk) disable iff (!rstN)
    !accByte |-> byteEn == 2'b11); // R9

endmodule

bind page_mapper page_mapper_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .vAddr    (vAddr),
  .accByte  (accByte),
  .physAddr (physAddr),
  .ioHit    (ioHit),
  .byteEn   (byteEn),
  .regAddr  (regAddr),
  .regRdata (regRdata)
);

// File: tb/page_mapper_bench.sv
`timescale 1ns/1ps
module page_mapper_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] vAddr = '0;
  logic [1:0]  modeBits = '0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic        accByte = 1'b0;
  logic [17:0] physAddr;
  logic        ioHit;
  logic [1:0]  byteEn;
  logic        regWr = 1'b0;
  logic [15:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] mPar [3][2][8];
  logic [15:0] mPdr [3][2][8];
  logic [15:0] mCtrl;

  always #2.5 clk = ~clk;

  page_mapper u_page_mapper (
    .clk(clk), .rstN(rstN), .vAddr(vAddr), .modeBits(modeBits),
    .accValid(accValid), .accWrite(accWrite), .accByte(accByte),
    .physAddr(physAddr), .ioHit(ioHit), .byteEn(byteEn),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic int bankOf(input logic [15:0] va, input logic [1:0] mode);
    if (va < 16'o1000) return 0;
    case (mode)
      2'b00:   return 0;
      2'b01:   return 1;
      default: return 2;
    endcase
  endfunction

  function automatic logic [15:0] regAddrOf(input int bank, input int kind, input int sp, input int pg);
    logic [15:0] b;
    b = (bank == 0) ? 16'o172300 : (bank == 1) ? 16'o172200 : 16'o177600;
    return b + 16'(kind * 32 + sp * 16 + pg * 2);
  endfunction

  function automatic logic [17:0] expPhys(input logic [15:0] va, input logic [1:0] mode);
    logic [21:0] s;
    if (va >= 16'o160000) return 18'o760000 + 18'(va[12:0]);
    s = {mPar[bankOf(va, mode)][0][va[15:13]], 6'b0};
    return s[17:0] + 18'(va[12:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWr = 1'b0;
    if ((a | 16'h1) == 16'o177573) mCtrl = d & ~16'h0C00;
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 8; p++)
            if ((a & 16'hFFFE) == regAddrOf(b, k, s, p)) begin
              if (k == 0) mPdr[b][s][p] = d; else mPar[b][s][p] = d;
            end
  endtask

  task automatic regCheck(input string req, input logic [15:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    check(req, {16'h0, regRdata}, {16'h0, exp});
  endtask

  task automatic xlat(input string req, input logic [15:0] va, input logic [1:0] mode,
                      input logic wr, input logic bt);
    logic [17:0] ep;
    vAddr = va; modeBits = mode; accWrite = wr; accByte = bt;
    #1;
    ep = expPhys(va, mode);
    check(req, {14'h0, physAddr}, {14'h0, ep});
    check("R4", {31'h0, ioHit}, {31'h0, va >= 16'o160000});
    check("R9", {30'h0, byteEn}, {30'h0, !bt ? 2'b11 : (ep[0] ? 2'b10 : 2'b01)});
    if (wr) begin
      accValid = 1'b1;
      tick();
      accValid = 1'b0;
      if (va < 16'o160000) mPdr[bankOf(va, mode)][0][va[15:13]][6] = 1'b1;
    end
    accWrite = 1'b0;
  endtask

  task automatic checkAllRegs(input string req);
    for (int b = 0; b < 3; b++)
      for (int k = 0; k < 2; k++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 8; p++)
            regCheck(req, regAddrOf(b, k, s, p), k == 0 ? mPdr[b][s][p] : mPar[b][s][p]);
    regCheck(req, 16'o177572, mCtrl);
  endtask

  initial begin
    #(5.0 * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 3; b++)
      for (int s = 0; s < 2; s++)
        for (int p = 0; p < 8; p++) begin
          mPar[b][s][p] = 16'(p * 128);
          mPdr[b][s][p] = 16'h7F06;
        end
    mCtrl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6 reset values
    checkAllRegs("R6");
    xlat("R1", 16'o034567, 2'b00, 1'b0, 1'b0);

    // R7 layout: distinct values per kind/space/page in user bank
    regWrite(regAddrOf(2, 1, 0, 3), 16'h0ABC);
    regWrite(regAddrOf(2, 1, 1, 3), 16'h0123);
    regWrite(regAddrOf(2, 0, 1, 5) | 16'h1, 16'h1234);  // odd address, R7
    regCheck("R7", regAddrOf(2, 0, 1, 5), 16'h1234);
    regCheck("R7", regAddrOf(2, 1, 0, 3) | 16'h1, 16'h0ABC);
    regWrite(16'o172400, 16'hFFFF);                      // unmapped write
    regCheck("R7", 16'o172400, 16'h0000);
    checkAllRegs("R7");

    // R2 bank per mode; R11 write visible next cycle
    regWrite(regAddrOf(0, 1, 0, 2), 16'h0100);
    regWrite(regAddrOf(1, 1, 0, 2), 16'h0200);
    regWrite(regAddrOf(2, 1, 0, 2), 16'h0300);
    xlat("R2", 16'o040010, 2'b00, 1'b0, 1'b0);
    xlat("R2", 16'o040010, 2'b01, 1'b0, 1'b0);
    xlat("R2", 16'o040010, 2'b11, 1'b0, 1'b0);
    xlat("R2", 16'o040010, 2'b10, 1'b0, 1'b0);
    xlat("R11", 16'o040010, 2'b11, 1'b0, 1'b0);

    // R3 low zone uses kernel bank even in user mode
    regWrite(regAddrOf(2, 1, 0, 0), 16'h0777);
    xlat("R3", 16'o000776, 2'b11, 1'b0, 1'b0);
    xlat("R3", 16'o001000, 2'b11, 1'b0, 1'b0);
    xlat("R5", 16'o000100, 2'b11, 1'b1, 1'b0);
    regCheck("R5", regAddrOf(0, 0, 0, 0), mPdr[0][0][0]);
    regCheck("R5", regAddrOf(2, 0, 0, 0), mPdr[2][0][0]);

    // R4 I/O page: pass-through, no marking
    xlat("R4", 16'o160000, 2'b11, 1'b1, 1'b0);
    xlat("R4", 16'o177777, 2'b00, 1'b1, 1'b1);
    xlat("R4", 16'o157777, 2'b00, 1'b0, 1'b1);
    regCheck("R4", regAddrOf(0, 0, 0, 7), mPdr[0][0][7]);

    // R5 read access does not mark
    xlat("R5", 16'o060000, 2'b01, 1'b0, 1'b0);
    regCheck("R5", regAddrOf(1, 0, 0, 3), 16'h7F06);
    xlat("R5", 16'o060001, 2'b01, 1'b1, 1'b1);
    regCheck("R5", regAddrOf(1, 0, 0, 3), 16'h7F46);

    // R1 truncation to 18 bits
    regWrite(regAddrOf(0, 1, 0, 1), 16'hFFFF);
    xlat("R1", 16'o037777, 2'b00, 1'b0, 1'b0);

    // R8 control register
    regWrite(16'o177572, 16'hFFFF);
    regCheck("R8", 16'o177572, 16'hF3FF);
    regCheck("R8", 16'o177573, 16'hF3FF);

    // R10 same-cycle collision on one descriptor
    regWr = 1'b1; regAddr = regAddrOf(2, 0, 0, 5); regWdata = 16'h1200;
    vAddr = 16'o120004; modeBits = 2'b11; accValid = 1'b1; accWrite = 1'b1; accByte = 1'b0;
    tick();
    regWr = 1'b0; accValid = 1'b0; accWrite = 1'b0;
    mPdr[2][0][5] = 16'h1240;
    regCheck("R10", regAddrOf(2, 0, 0, 5), 16'h1240);
    // collision on different pages: both effects kept
    regWr = 1'b1; regAddr = regAddrOf(2, 0, 0, 6); regWdata = 16'h0002;
    vAddr = 16'o020000; modeBits = 2'b11; accValid = 1'b1; accWrite = 1'b1;
    tick();
    regWr = 1'b0; accValid = 1'b0; accWrite = 1'b0;
    mPdr[2][0][6] = 16'h0002;
    mPdr[2][0][1][6] = 1'b1;
    regCheck("R10", regAddrOf(2, 0, 0, 6), 16'h0002);
    regCheck("R10", regAddrOf(2, 0, 0, 1), mPdr[2][0][1]);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0) begin
        regWrite(regAddrOf($urandom_range(0, 2), $urandom_range(0, 1),
                           $urandom_range(0, 1), $urandom_range(0, 7)), 16'($urandom));
      end else begin
        xlat("R1", 16'($urandom), 2'($urandom), op == 2, 1'($urandom));
      end
    end
    checkAllRegs("R5");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule